// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Boot Address Loader

This block reads 16-bit words from a small three-wire serial EEPROM of the 64-word kind. A read is a single transaction. The block raises chip select, sends an 11-bit read frame carrying a 6-bit word address, and clocks in sixteen data bits. It then closes the access and reports the word with a one-cycle done pulse. One parameter sets the shift-clock speed as a number of system clocks per half period.

When reset is released, a built-in loader reads words 0 to 11 in ascending order. Four of these words, 6 to 9, hold a 48-bit station address, but it is stored shifted by one bit across word boundaries. The loader rebuilds the address and publishes it with a valid flag. After that the host port is free. A host asserts a request with an address while the block is not busy, and collects the word when done pulses.

Top module: `mw_eeprom_reader`

## Requirements
- R1: Every read frame is 11 bits and goes out most significant bit first. Its first two bits are 0, the next three are the read opcode 1,1,0, and the last six are the word address from bit 5 down to bit 0.
- R2: Each access begins with HALF_CLKS cycles of chip select high, with shift clock and data-out low. For each frame bit, data-out holds the bit for HALF_CLKS cycles with the shift clock low, then for HALF_CLKS cycles with the shift clock high. Data-out does not change while the shift clock is high.
- R3: After the frame and one HALF_CLKS gap with the clock low, sixteen high/low clock pairs follow. The input level at the end of the k-th high phase (k counted from 0) becomes bit k of the returned word.
- R4: After the last data bit, chip select stays high with clock and data-out low for HALF_CLKS cycles, then drops. In that same cycle done pulses for exactly one cycle with the word on rd_data. From the accepting clock edge to done takes 57*HALF_CLKS cycles.
- R5: busy is high from the cycle after an accepted request until the done cycle, and it is low in the done cycle. A request seen while busy is high is ignored. A request in the done cycle is accepted.
- R6: Chip select and shift clock are low during reset and whenever no access is running. The shift clock is never high while chip select is low, and a reset during an access drops chip select.
- R7: After reset the loader reads words 0 through 11, in that order and each exactly once. busy stays high and host requests are ignored until addr_valid rises.
- R8: For i = 0..2, station_addr byte 2i (bits 16i+7..16i) is {word[7+i][6:0], word[6+i][15]}, and byte 2i+1 (bits 16i+15..16i+8) is word[7+i][14:7]. Once addr_valid is high, it and station_addr stay unchanged until reset.
- R9: done pulses only for host reads, never for the loader's reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Host read request, taken when busy is low |
| rd_addr | input | 6 | Word address of the host read |
| busy | output | 1 | Access or boot load in progress |
| done | output | 1 | One-cycle pulse: host read complete |
| rd_data | output | 16 | Word returned by the last read |
| station_addr | output | 48 | Rebuilt station address |
| addr_valid | output | 1 | Boot load finished, station_addr valid |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
Two events meet at the end of every host read: the done pulse, with busy falling, and the host's next request. The bench raises the next request in the very cycle done is seen. It expects that request to start a new frame on the following edge. The reference model then checks every later pin level against the new address. The bench also holds requests during a running access and during the boot load. In those cases the model expects the pins, busy and the returned word to follow the original access only. A device model records every frame address it receives, so an accepted stray request shows up in that log.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;

    // Serial access phases, one per half shift-clock slot
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_CMD_LO,
        PH_CMD_HI,
        PH_GAP,
        PH_DAT_HI,
        PH_DAT_LO,
        PH_TAIL
    } mw_phase_e;

    typedef enum logic [1:0] {
        BT_ISSUE,
        BT_WAIT,
        BT_DONE
    } boot_state_e;

    localparam logic [2:0] RD_OPCODE   = 3'b110;
    localparam int         LEAD_ZEROS  = 2;
    localparam int         BOOT_WORDS  = 12;
    localparam int         SA_FIRST    = 6;
    localparam int         SA_WORDS    = 4;

endpackage

// File: rtl/mw_bit_engine.sv
module mw_bit_engine
    import mw_rd_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int HALF_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sdo,
    output logic              cs,
    output logic              sk,
    output logic              di,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    localparam int H     = (HALF_CLKS < 1) ? 1 : HALF_CLKS;
    localparam int TW    = (H > 1) ? $clog2(H) : 1;
    localparam int CMD_W = LEAD_ZEROS + 3 + ADDR_W;
    localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CW    = $clog2(MAXB);

    typedef struct packed {
        mw_phase_e          ph;
        logic [TW-1:0]      tmr;
        logic [CW-1:0]      cnt;
        logic [CMD_W-1:0]   cmd;
        logic [DATA_W-1:0]  data;
        logic               done;
    } eng_t;

    eng_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.ph == PH_IDLE) begin
            if (start) begin
                r_d.ph  = PH_LEAD;
                r_d.tmr = '0;
                r_d.cnt = '0;
                r_d.cmd = {{LEAD_ZEROS{1'b0}}, RD_OPCODE, addr};
            end
        end else if (r_q.tmr != TW'(H - 1)) begin
            r_d.tmr = r_q.tmr + 1'b1;
        end else begin
            r_d.tmr = '0;
            case (r_q.ph)
                PH_LEAD:   r_d.ph = PH_CMD_LO;
                PH_CMD_LO: r_d.ph = PH_CMD_HI;
                PH_CMD_HI: begin
                    if (r_q.cnt == CW'(CMD_W - 1)) begin
                        r_d.ph  = PH_GAP;
                        r_d.cnt = '0;
                    end else begin
                        r_d.ph  = PH_CMD_LO;
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.cmd = {r_q.cmd[CMD_W-2:0], 1'b0};
                    end
                end
                PH_GAP:    r_d.ph = PH_DAT_HI;
                PH_DAT_HI: begin
                    r_d.data[r_q.cnt] = sdo;
                    r_d.ph            = PH_DAT_LO;
                end
                PH_DAT_LO: begin
                    if (r_q.cnt == CW'(DATA_W - 1)) begin
                        r_d.ph  = PH_TAIL;
                        r_d.cnt = '0;
                    end else begin
                        r_d.ph  = PH_DAT_HI;
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                PH_TAIL: begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                end
                default:   r_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, tmr: '0, cnt: '0, cmd: '0, data: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign active = (r_q.ph != PH_IDLE);
    assign cs     = active;
    assign sk     = (r_q.ph == PH_CMD_HI) || (r_q.ph == PH_DAT_HI);
    assign di     = ((r_q.ph == PH_CMD_LO) || (r_q.ph == PH_CMD_HI)) && r_q.cmd[CMD_W-1];
    assign done   = r_q.done;
    assign data   = r_q.data;

endmodule

// File: rtl/mw_boot_seq.sv
module mw_boot_seq
    import mw_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             eng_done,
    input  logic [DATA_W-1:0]                eng_data,
    output logic                             start,
    output logic [ADDR_W-1:0]                addr,
    output logic                             loaded,
    output logic [SA_WORDS-1:0][DATA_W-1:0]  words
);
    localparam int IW = $clog2(BOOT_WORDS);
    localparam int SW = $clog2(SA_WORDS);

    typedef struct packed {
        boot_state_e                      st;
        logic [IW-1:0]                    idx;
        logic [SA_WORDS-1:0][DATA_W-1:0]  words;
    } boot_t;

    boot_t s_q, s_d;
    logic  in_window;

    assign in_window = (s_q.idx >= IW'(SA_FIRST)) && (s_q.idx < IW'(SA_FIRST + SA_WORDS));

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            BT_ISSUE: s_d.st = BT_WAIT;
            BT_WAIT: begin
                if (eng_done) begin
                    if (in_window) begin
                        s_d.words[SW'(s_q.idx - IW'(SA_FIRST))] = eng_data;
                    end
                    if (s_q.idx == IW'(BOOT_WORDS - 1)) begin
                        s_d.st = BT_DONE;
                    end else begin
                        s_d.st  = BT_ISSUE;
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.st = BT_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: BT_ISSUE, idx: '0, words: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign start  = (s_q.st == BT_ISSUE);
    assign addr   = ADDR_W'(s_q.idx);
    assign loaded = (s_q.st == BT_DONE);
    assign words  = s_q.words;

endmodule

// File: rtl/mw_station_addr.sv
module mw_station_addr
    import mw_rd_pkg::*;
(
    input  logic [SA_WORDS-1:0][15:0]      words,
    output logic [16*(SA_WORDS-1)-1:0]     station
);
    // The stored address is shifted up by one bit across word boundaries
    for (genvar i = 0; i < SA_WORDS - 1; i++) begin : g_pair
        assign station[16*i +: 8]     = {words[i+1][6:0], words[i][15]};
        assign station[16*i + 8 +: 8] = words[i+1][14:7];
    end

    logic unused_bits;
    assign unused_bits = ^{words[0][14:0], words[SA_WORDS-1][15]};

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
    import mw_rd_pkg::*;
#(
    parameter int HALF_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic [5:0]  rd_addr,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic [47:0] station_addr,
    output logic        addr_valid,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do
);
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;

    logic                             eng_start, eng_active, eng_done;
    logic [ADDR_W-1:0]                eng_addr, boot_addr;
    logic [DATA_W-1:0]                eng_data;
    logic                             boot_start, boot_loaded, host_go;
    logic [SA_WORDS-1:0][DATA_W-1:0]  boot_words;

    assign busy      = !boot_loaded || eng_active;
    assign host_go   = rd_req && !busy;
    assign eng_start = boot_start || host_go;
    assign eng_addr  = boot_loaded ? rd_addr : boot_addr;

    mw_bit_engine #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .HALF_CLKS (HALF_CLKS)
    ) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .addr   (eng_addr),
        .sdo    (ee_do),
        .cs     (ee_cs),
        .sk     (ee_sk),
        .di     (ee_di),
        .active (eng_active),
        .done   (eng_done),
        .data   (eng_data)
    );

    mw_boot_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_boot (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_done (eng_done),
        .eng_data (eng_data),
        .start    (boot_start),
        .addr     (boot_addr),
        .loaded   (boot_loaded),
        .words    (boot_words)
    );

    mw_station_addr u_sa (
        .words   (boot_words),
        .station (station_addr)
    );

    assign done       = eng_done && boot_loaded;
    assign rd_data    = eng_data;
    assign addr_valid = boot_loaded;

endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        addr_valid,
    input logic [47:0] station_addr,
    input logic        ee_cs,
    input logic        ee_sk,
    input logic        ee_di
);
    // R6: no shift clock without chip select
    p_sk_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    // R2: data-out is steady while the shift clock stays high
    p_di_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R4: done comes with chip select low and busy low, and lasts one cycle
    p_done_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ee_cs && !busy));
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: busy only falls at a host done or at the end of the boot load
    p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || $rose(addr_valid)));

    // R8: the station address is frozen once valid
    p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (addr_valid && $stable(station_addr)));

    // R9: no done pulse during the boot load
    p_boot_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> !done);

endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk u_chk (.*);

// File: tb/sim_mw_eeprom_reader.sv
`timescale 1ns/1ps
module sim_mw_eeprom_reader;
    localparam int HC  = 2;
    localparam int ACC = 57 * HC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        busy, done, addr_valid;
    logic [15:0] rd_data;
    logic [47:0] station_addr;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    always #4 clk = ~clk;

    mw_eeprom_reader #(.HALF_CLKS(HC)) u0 (.*);

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- EEPROM device model ----------------
    logic [15:0] mem [64];
    int          rcnt = 0;
    logic [10:0] sh = '0;
    logic [5:0]  cur = '0;
    int          addr_log [$];

    task automatic fill_mem(input int seed);
        for (int i = 0; i < 64; i++) mem[i] = 16'((i * 40503 + seed) ^ (i << 9));
    endtask

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            if (rcnt < 11) begin
                sh = {sh[9:0], ee_di};
                rcnt++;
                if (rcnt == 11) begin
                    // R1: frame prefix must be 00 then read opcode 110
                    chk(sh[10:6] == 5'b00110, "R1", 64'(sh[10:6]), 64'h6);
                    cur = sh[5:0];
                    addr_log.push_back(int'(sh[5:0]));
                end
            end else if (rcnt < 27) begin
                ee_do = mem[cur][rcnt - 11];
                rcnt++;
            end
        end
    end

    always @(negedge ee_cs) begin
        rcnt  = 0;
        ee_do = 1'b0;
    end

    // ---------------- cycle reference model ----------------
    int          acc_c = -1;
    logic [5:0]  m_addr = '0;
    bit          exp_done = 0;
    logic        av_s = 1'b0;
    bit          check_en = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            acc_c    = -1;
            exp_done = 0;
        end else begin
            exp_done = 0;
            if (acc_c >= 0) begin
                acc_c++;
                if (acc_c == ACC) begin
                    acc_c    = -1;
                    exp_done = 1;
                end
            end else if (rd_req && av_s) begin
                acc_c  = 0;
                m_addr = rd_addr;
            end
        end
    end

    function automatic logic [2:0] exp_pins(input int c, input logic [5:0] a);
        int          p;
        logic [10:0] f;
        p = c / HC;
        f = {2'b00, 3'b110, a};
        if (p == 0 || p == 23 || p == 56) return 3'b100;
        if (p <= 22) return {1'b1, ((p - 1) % 2) == 1, f[10 - (p - 1) / 2]};
        return {1'b1, ((p - 24) % 2) == 0, 1'b0};
    endfunction

    always @(negedge clk) begin
        av_s = addr_valid;
        if (rst_n && check_en) begin
            if (!addr_valid) begin
                chk(busy == 1'b1, "R7", 64'(busy), 64'h1);
                chk(done == 1'b0, "R9", 64'(done), 64'h0);
            end else begin
                chk(busy == (acc_c >= 0), "R5", 64'(busy), 64'(acc_c >= 0));
                chk(done == exp_done, "R4", 64'(done), 64'(exp_done));
                if (exp_done)
                    chk(rd_data == mem[m_addr], "R3", 64'(rd_data), 64'(mem[m_addr]));
                if (acc_c >= 0)
                    chk({ee_cs, ee_sk, ee_di} == exp_pins(acc_c, m_addr), "R2",
                        64'({ee_cs, ee_sk, ee_di}), 64'(exp_pins(acc_c, m_addr)));
                else
                    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R6", 64'({ee_cs, ee_sk, ee_di}), 64'h0);
            end
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [47:0] exp_station();
        logic [47:0] s;
        for (int i = 0; i < 3; i++) begin
            s[16*i +: 8]     = {mem[7+i][6:0], mem[6+i][15]};
            s[16*i + 8 +: 8] = mem[7+i][14:7];
        end
        return s;
    endfunction

    task automatic do_boot(input int seed);
        fill_mem(seed);
        addr_log.delete();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R6: reset state
        chk({ee_cs, ee_sk} == 2'b00, "R6", 64'({ee_cs, ee_sk}), 64'h0);
        chk(done == 1'b0, "R9", 64'(done), 64'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        rd_req = 1'b1; rd_addr = 6'h2A;           // R7: ignored during boot
        repeat (5) @(negedge clk);
        rd_req = 1'b0;
        while (!addr_valid) @(negedge clk);
        chk(addr_log.size() == 12, "R7", 64'(addr_log.size()), 64'd12);
        for (int i = 0; i < 12 && i < addr_log.size(); i++)
            chk(addr_log[i] == i, "R7", 64'(addr_log[i]), 64'(i));
        chk(station_addr == exp_station(), "R8", station_addr, exp_station());
        addr_log.delete();
    endtask

    task automatic host_read(input logic [5:0] a);
        while (busy) @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic read_with_noise(input logic [5:0] a, input logic [5:0] b);
        while (busy) @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (10) @(negedge clk);
        rd_req = 1'b1; rd_addr = b;               // R5: ignored while busy
        repeat (3) @(negedge clk);
        rd_req = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        check_en = 1;
        do_boot(16'h1234);
        host_read(6'h00);
        host_read(6'h3F);                         // issued in the done cycle
        host_read(6'h15);
        read_with_noise(6'h2C, 6'h01);
        chk(addr_log.size() == 4, "R5", 64'(addr_log.size()), 64'd4);
        if (addr_log.size() == 4) begin
            chk(addr_log[1] == 'h3F, "R1", 64'(addr_log[1]), 64'h3F);
            chk(addr_log[3] == 'h2C, "R5", 64'(addr_log[3]), 64'h2C);
        end
        // R6: reset in the middle of an access drops chip select
        while (busy) @(negedge clk);
        rd_req = 1'b1; rd_addr = 6'h09;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({ee_cs, ee_sk} == 2'b00, "R6", 64'({ee_cs, ee_sk}), 64'h0);
        do_boot(16'hBEEF);
        host_read(6'h07);
        host_read(6'h3E);
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule